// File: doc/BRIEF.md
# Spread-Spectrum Modulation Profile Generator

This block produces a signed, stepwise frequency-offset word that a synthesizer control loop adds to its divider setting, which spreads the output spectrum and lowers peak emissions. The profile is built from lobes. A lobe ramps the offset away from zero to a peak and then back to zero. In the down-spread modes every lobe is negative. In the center-spread modes negative and positive lobes alternate, so the profile swings evenly about zero.

Software sets an up-step count, a down-step count that is stored negated, a step period in base-time units, a depth select and a profile style. The block keeps a shadow copy of all of these and takes in new settings only when a lobe ends at zero, so a profile never jumps. Each step raises a one-cycle strobe, updates the offset and reports the direction the offset moved.

Top module: `ssc_profile_gen`

## Requirements
- R1: While `mod_en` is low the offset, the direction flag and the strobe are held at zero, and the step counters and lobe state are cleared.
- R2: The up count `up_steps` is unsigned, and a value of 0 counts as 1. A positive lobe ramps away from zero in that many steps.
- R3: The down count `down_steps_n` holds the negated count in 4-bit two's complement. A field value v gives 16−v steps (1111→1, 1110→2, 1001→7, 1000→8), and 0000 gives 16. A negative lobe ramps away from zero in that many steps.
- R4: A step occurs every TICK_DIV×max(step_period,1) clock cycles, where TICK_DIV clock cycles make one base unit of 280 ns. `step_stb` pulses for one cycle in the cycle the new offset appears.
- R5: The peak magnitude P depends on `depth_sel`: 00 gives down 1% with P = FULL_SCALE, 01 gives down 0.5% with P = FULL_SCALE/2, 10 gives center ±0.5% with P = FULL_SCALE/2, and 11 gives center ±0.25% with P = FULL_SCALE/4. At step k of a ramp of n steps the magnitude is floor(P·k/n) on the way out and floor(P·(n_total−k)/n_back) on the way back.
- R6: When `depth_sel[1]` is 0 the offset is never positive. When it is 1, a lobe that ends is followed by a lobe of the opposite sign, and the first lobe after enable is negative.
- R7: With `pendulum`=1 the return to zero takes the count of the opposite direction: the up count after a negative lobe and the down count after a positive lobe.
- R8: With `pendulum`=0 the offset returns from the peak to zero in a single step.
- R9: Changes to any configuration input take effect only at the step that brings a lobe back to zero, or while the block is disabled.
- R10: `dir_up` is 1 after a step that moved the offset toward positive and 0 after a step that moved it toward negative.
- R11: After reset the offset is 0 and `dir_up` and `step_stb` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mod_en | input | 1 | Enables modulation; low forces the offset to zero |
| up_steps | input | 4 | Up-step count (0 counts as 1) |
| down_steps_n | input | 4 | Down-step count, negated two's complement |
| step_period | input | 6 | Step time in base units (0 counts as 1) |
| depth_sel | input | 2 | Spread type and depth select |
| pendulum | input | 1 | 1 = pendulum profile, 0 = original profile |
| offset | output | OFS_W | Signed frequency offset |
| dir_up | output | 1 | Direction of the last step |
| step_stb | output | 1 | One-cycle pulse at each step |

## Verification
The bench aims at these cases. A down field of 0000 must give 16 steps; a design that read it as zero would end the lobe at once or divide by zero. A step period of 0 must give one unit; a period counter that wraps would stall for 64 units. Configuration is changed in the middle of lobes, and a design that applied it at once would produce offset jumps the model does not expect. Long single-step returns in original style and center lobes that switch sign are also covered: a design that skipped the sign switch would stay below zero in center mode, and one with wrong step counts would reach the peak in the wrong cycle.

// File: rtl/ssc_profile_gen.sv
module ssc_profile_gen #(
  parameter int OFS_W      = 12,
  parameter int FULL_SCALE = 1024,
  parameter int TICK_DIV   = 7
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    mod_en,
  input  logic [3:0]              up_steps,
  input  logic [3:0]              down_steps_n,
  input  logic [5:0]              step_period,
  input  logic [1:0]              depth_sel,
  input  logic                    pendulum,
  output logic signed [OFS_W-1:0] offset,
  output logic                    dir_up,
  output logic                    step_stb
);
  localparam int TW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int NW = $clog2(FULL_SCALE + 1) + 6;
  localparam logic [TW-1:0] UNIT_LAST = TW'(TICK_DIV - 1);

  logic [TW-1:0] unit_q;
  logic [5:0]    per_cnt_q, j_q;
  logic          pos_q;
  logic [3:0]    up_q, dn_q;
  logic [5:0]    per_q;
  logic [1:0]    dep_q;
  logic          pend_q;

  logic [5:0] u_len, d_len, a_len, b_len, tot, jn, per_eff, div;
  logic [NW-1:0] pk, num, mag;
  logic          away, unit_tick, step_now;
  logic signed [OFS_W-1:0] ofs_next;

  assign u_len   = (up_q == 4'd0) ? 6'd1 : {2'b00, up_q};
  assign d_len   = {2'b00, ~dn_q} + 6'd1;
  assign a_len   = pos_q ? u_len : d_len;
  assign b_len   = pend_q ? (pos_q ? d_len : u_len) : 6'd1;
  assign tot     = a_len + b_len;
  assign jn      = j_q + 6'd1;
  assign away    = jn <= a_len;
  assign per_eff = (per_q == 6'd0) ? 6'd1 : per_q;

  always_comb begin
    case (dep_q)
      2'b00:   pk = NW'(FULL_SCALE);
      2'b01,
      2'b10:   pk = NW'(FULL_SCALE / 2);
      default: pk = NW'(FULL_SCALE / 4);
    endcase
  end

  assign div      = away ? a_len : b_len;
  assign num      = pk * NW'(away ? jn : tot - jn);
  assign mag      = num / NW'(div);
  assign ofs_next = pos_q ? $signed(mag[OFS_W-1:0]) : -$signed(mag[OFS_W-1:0]);

  assign unit_tick = unit_q == UNIT_LAST;
  assign step_now  = mod_en && unit_tick && (per_cnt_q == per_eff - 6'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unit_q <= '0; per_cnt_q <= '0; j_q <= '0; pos_q <= 1'b0;
      offset <= '0; dir_up <= 1'b0; step_stb <= 1'b0;
      up_q <= 4'd1; dn_q <= 4'hF; per_q <= 6'd1; dep_q <= 2'b11; pend_q <= 1'b1;
    end else if (!mod_en) begin
      unit_q <= '0; per_cnt_q <= '0; j_q <= '0; pos_q <= 1'b0;
      offset <= '0; dir_up <= 1'b0; step_stb <= 1'b0;
      up_q <= up_steps; dn_q <= down_steps_n; per_q <= step_period;
      dep_q <= depth_sel; pend_q <= pendulum;
    end else begin
      step_stb <= step_now;
      unit_q   <= unit_tick ? '0 : unit_q + 1'b1;
      if (unit_tick)
        per_cnt_q <= (per_cnt_q == per_eff - 6'd1) ? 6'd0 : per_cnt_q + 6'd1;
      if (step_now) begin
        dir_up <= away ? pos_q : ~pos_q;
        if (jn == tot) begin
          j_q    <= '0;
          offset <= '0;
          pos_q  <= depth_sel[1] & ~pos_q;
          up_q <= up_steps; dn_q <= down_steps_n; per_q <= step_period;
          dep_q <= depth_sel; pend_q <= pendulum;
        end else begin
          j_q    <= jn;
          offset <= ofs_next;
        end
      end
    end
  end
endmodule

// File: rtl/ssc_profile_chk.sv
module ssc_profile_chk #(
  parameter int OFS_W      = 12,
  parameter int FULL_SCALE = 1024
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    mod_en,
  input logic                    step_now,
  input logic                    step_stb,
  input logic                    dir_up,
  input logic signed [OFS_W-1:0] offset,
  input logic [1:0]              dep_q,
  input logic [3:0]              up_q,
  input logic [3:0]              dn_q,
  input logic [5:0]              per_q,
  input logic                    pend_q
);
  a_r1_off_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !mod_en |=> (offset == 0 && !step_stb));

  a_r6_down_nonpos: assert property (@(posedge clk) disable iff (!rst_n)
    !dep_q[1] |-> offset <= 0);

  a_r5_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (offset >= -FULL_SCALE) && (offset <= FULL_SCALE));

  a_r9_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_en && !step_now) |=> $stable({up_q, dn_q, per_q, dep_q, pend_q}));

  a_r4_quiet_between: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_en && !step_now) |=> $stable(offset));

  a_r10_dir_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (step_stb && offset > $past(offset)) |-> dir_up);
endmodule

bind ssc_profile_gen ssc_profile_chk #(.OFS_W(OFS_W), .FULL_SCALE(FULL_SCALE)) chk_i (
  .clk(clk), .rst_n(rst_n), .mod_en(mod_en), .step_now(step_now),
  .step_stb(step_stb), .dir_up(dir_up), .offset(offset), .dep_q(dep_q),
  .up_q(up_q), .dn_q(dn_q), .per_q(per_q), .pend_q(pend_q)
);

// File: tb/ssc_profile_gen_tb_top.sv
module ssc_profile_gen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int OFS_W = 12, FULL = 1024, TICK = 7;

  logic clk = 1'b0, rst_n = 1'b0, mod_en = 1'b0, pendulum = 1'b1;
  logic [3:0] up_steps = 4'd1, down_steps_n = 4'hF;
  logic [5:0] step_period = 6'd1;
  logic [1:0] depth_sel = 2'b11;
  logic signed [OFS_W-1:0] offset;
  logic dir_up, step_stb;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  int m_u, m_d, m_per, m_dep, m_pend, m_j, m_pos, gap;

  ssc_profile_gen #(.OFS_W(OFS_W), .FULL_SCALE(FULL), .TICK_DIV(TICK)) dut_i (
    .clk(clk), .rst_n(rst_n), .mod_en(mod_en), .up_steps(up_steps),
    .down_steps_n(down_steps_n), .step_period(step_period), .depth_sel(depth_sel),
    .pendulum(pendulum), .offset(offset), .dir_up(dir_up), .step_stb(step_stb));

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc++;

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int up_len(int v); return (v == 0) ? 1 : v; endfunction
  function automatic int dn_len(int v); return (v == 0) ? 16 : 16 - v; endfunction
  function automatic int peak(int dep);
    case (dep)
      0: return FULL;
      1, 2: return FULL / 2;
      default: return FULL / 4;
    endcase
  endfunction

  task automatic load_model();
    m_u = up_len(up_steps); m_d = dn_len(down_steps_n);
    m_per = (step_period == 0) ? 1 : step_period;
    m_dep = depth_sel; m_pend = pendulum;
  endtask

  task automatic on_strobe();
    int a, b, tot, jn, mag, exp, edir;
    string tag;
    check(gap == TICK * m_per, "R4 step interval", gap, TICK * m_per);
    gap = 0;
    a = m_pos ? m_u : m_d;
    b = m_pend ? (m_pos ? m_d : m_u) : 1;
    tot = a + b; jn = m_j + 1;
    if (jn <= a) begin
      mag = peak(m_dep) * jn / a; edir = m_pos;
      tag = (jn == a) ? "R5 peak" : (m_pos ? "R2 up ramp" : "R3 down ramp");
    end else begin
      mag = peak(m_dep) * (tot - jn) / b; edir = !m_pos;
      tag = m_pend ? "R7 pendulum return" : "R8 single-step return";
    end
    exp = m_pos ? mag : -mag;
    check(offset == exp, tag, offset, exp);
    check(dir_up == edir, "R10 direction", dir_up, edir);
    if (m_dep < 2) check(offset <= 0, "R6 down non-positive", offset, 0);
    else check(m_pos ? offset >= 0 : offset <= 0, "R6 lobe sign", offset, exp);
    if (jn == tot) begin
      m_j = 0;
      m_pos = depth_sel[1] & !m_pos;
      load_model();
    end else m_j = jn;
  endtask

  task automatic run_segment(int u, int dn, int per, int dep, int pend, int nstr, bit chg);
    int seen = 0;
    @(negedge clk);
    mod_en = 0; up_steps = u[3:0]; down_steps_n = dn[3:0];
    step_period = per[5:0]; depth_sel = dep[1:0]; pendulum = pend[0];
    repeat (2) @(negedge clk);
    check(offset == 0 && !step_stb, "R1 disabled holds zero", offset, 0);
    load_model(); m_j = 0; m_pos = 0; gap = 0;
    mod_en = 1;
    while (seen < nstr) begin
      @(negedge clk);
      gap++;
      if (step_stb) begin on_strobe(); seen++; end
      if (chg && ($urandom % 40 == 0)) begin
        up_steps = 4'($urandom); down_steps_n = 4'($urandom);
        step_period = 6'(1 + $urandom % 3); depth_sel = 2'($urandom);
        pendulum = 1'($urandom);
      end
    end
  endtask

  initial begin
    void'($urandom(32'h5C5_0F5E));
    repeat (3) @(negedge clk);
    check(offset == 0, "R11 reset offset", offset, 0);
    check(!dir_up && !step_stb, "R11 reset flags", {dir_up, step_stb}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    for (int i = 0; i < 5; i++) begin
      up_steps = 4'($urandom); depth_sel = 2'($urandom);
      @(negedge clk);
      check(offset == 0 && !step_stb, "R1 idle with changing inputs", offset, 0);
    end
    run_segment(1, 4'hF, 1, 0, 1, 6, 0);
    run_segment(0, 4'h0, 0, 0, 1, 40, 0);
    run_segment(3, 4'h8, 2, 1, 0, 30, 0);
    run_segment(5, 4'h9, 1, 2, 1, 60, 0);
    run_segment(4, 4'hE, 1, 3, 0, 40, 0);
    run_segment(2, 4'hD, 63, 3, 1, 5, 0);
    for (int s = 0; s < 24; s++)
      run_segment($urandom % 16, $urandom % 16, 1 + $urandom % 4, $urandom % 4,
                  $urandom % 2, 20 + $urandom % 40, 1);
    @(negedge clk); mod_en = 0;
    @(negedge clk); @(negedge clk);
    check(offset == 0 && !dir_up, "R1 disable clears", offset, 0);
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    wait (cyc >= 190000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule